// File: doc/BRIEF.md
# DRAM Bank Decode and Column-Strobe Steering

This block is the glue between a 24-bit CPU address bus, a DMA/RAM arbiter and up to four 512KB DRAM banks. It decodes each CPU address into a chip-RAM region at the bottom of the map or a slow-RAM window starting at 0xC00000. For a hit it drives an active-low RAM-enable to the arbiter. It also drives a register-enable so the arbiter runs a RAM cycle for slow banks it cannot address on its own. A configuration input picks which CPU address line the arbiter sees as its bank-select bit. One setting gives 1MB of contiguous chip RAM. The other pushes the second 512KB up into the slow window.

Banks are chosen by steering the arbiter's two column strobes, one per byte lane, to one of four banks through a 2-bit bank index. The two row strobes are passed straight through and never gated, so row-only refresh still reaches every bank. The bank index is taken from CPU A20:A19 and registered when a row strobe first goes low. It is held for the whole memory cycle. While the DMA-active input is low, the index is forced to the second chip bank.

Top module: `dram_bank_steer`

## Requirements
- R1: With `cpu_as_n` low, an address from 0x000000 to 0x07FFFF drives `ram_en_n` low. With `cpu_as_n` high, `ram_en_n` and `reg_en_n` are both high.
- R2: With `cfg_contig` = 1, `bank_sel` equals `cpu_addr[19]` and addresses 0x080000 to 0x0FFFFF also drive `ram_en_n` low. With `cfg_contig` = 0, `bank_sel` equals `cpu_addr[23]` and 0x080000 to 0x0FFFFF leave `ram_en_n` high.
- R3: Addresses 0xC00000 to 0xD7FFFF drive `ram_en_n` low. Every address from 0xD80000 upward leaves it high. `reg_en_n` is low only for 0xC80000 to 0xD7FFFF.
- R4: The bank index is `cpu_addr[20:19]`, registered at the first rising clock edge where either bit of `ras_in_n` is sampled low. It is held unchanged until both bits are sampled high, whatever the address does meanwhile.
- R5: For bank b equal to the held index, `cas_out_n[2*b+1]` follows `cas_in_n[1]` (upper byte) and `cas_out_n[2*b]` follows `cas_in_n[0]` (lower byte). All other `cas_out_n` bits are high.
- R6: When both `cas_in_n` bits are high, all eight `cas_out_n` bits are high.
- R7: `ras_out_n` equals `ras_in_n` at all times, including before a capture and while DMA is active.
- R8: If `dma_n` is low at the capturing edge, the index is 1 (the second chip bank), regardless of the address.
- R9: After reset the held index is 0, so column strobes go to bank 0 until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 24 | CPU byte address |
| cpu_as_n | input | 1 | Active-low CPU address valid |
| cfg_contig | input | 1 | 1: bank-select from A19 (1MB chip), 0: from A23 |
| dma_n | input | 1 | Active-low DMA cycle in progress |
| ras_in_n | input | 2 | Row strobes from the arbiter |
| cas_in_n | input | 2 | Column strobes from the arbiter, [1] upper byte, [0] lower byte |
| ram_en_n | output | 1 | Active-low RAM-enable to the arbiter |
| reg_en_n | output | 1 | Active-low register-enable for the extended slow banks |
| bank_sel | output | 1 | Bank-select bit seen by the arbiter |
| ras_out_n | output | 2 | Row strobes to the banks, ungated |
| cas_out_n | output | 8 | Column strobes, bit 2*bank+lane |

## Verification
The decode outputs, the row-strobe pass-through and the column-strobe gating are combinational. They are due in the same cycle as the inputs, so the bench samples them a short delay after driving each step, well before the next rising edge. The bank index takes one register stage. A row strobe driven low in one step changes the steering only from the next step, after the capturing edge. The reference model updates its own index at that same edge and then compares every output on every cycle, so capture, hold and release are each checked at the cycle they are due.

// File: rtl/dram_steer_pkg.sv
package dram_steer_pkg;

  // Result of decoding one CPU address.
  typedef struct packed {
    logic ram_hit;   // address lies in chip or slow RAM
    logic ext_hit;   // address lies in the slow banks the arbiter cannot reach
    logic sel_bit;   // bank-select bit presented to the arbiter
  } decode_t;

endpackage

// File: rtl/steer_reset_sync.sv
module steer_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/steer_addr_decode.sv
module steer_addr_decode
  import dram_steer_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter int              BANK_BIT  = 19,
  parameter int              HIGH_BIT  = 23,
  parameter logic [23:0]     SLOW_BASE = 24'hC00000,
  parameter logic [23:0]     SLOW_END  = 24'hD7FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_as_n,
  input  logic              cfg_contig,
  output decode_t           dec
);

  localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(1) << BANK_BIT;
  localparam logic [ADDR_W-1:0] CHIP_LIM1 = BANK_SPAN;
  localparam logic [ADDR_W-1:0] CHIP_LIM2 = BANK_SPAN << 1;
  localparam logic [ADDR_W-1:0] S_BASE    = SLOW_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] S_END     = SLOW_END[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] EXT_BASE  = S_BASE + BANK_SPAN;

  logic chip_hit;
  logic slow_hit;
  logic ext_range;

  always_comb begin
    if (cfg_contig) chip_hit = (cpu_addr < CHIP_LIM2);
    else            chip_hit = (cpu_addr < CHIP_LIM1);
    slow_hit  = (cpu_addr >= S_BASE) && (cpu_addr <= S_END);
    ext_range = (cpu_addr >= EXT_BASE) && (cpu_addr <= S_END);

    dec.ram_hit = !cpu_as_n && (chip_hit || slow_hit);
    dec.ext_hit = !cpu_as_n && ext_range;
    dec.sel_bit = cfg_contig ? cpu_addr[BANK_BIT] : cpu_addr[HIGH_BIT];
  end

  // Nothing at or above the end of the slow window is ever RAM.
  p_no_ram_above_window_r3: assert property (
    @(posedge clk) disable iff (!rst_n)
      (cpu_addr > S_END) |-> !dec.ram_hit);

  // An idle bus never enables RAM.
  p_idle_bus_quiet_r1: assert property (
    @(posedge clk) disable iff (!rst_n)
      cpu_as_n |-> (!dec.ram_hit && !dec.ext_hit));

endmodule

// File: rtl/steer_bank_latch.sv
module steer_bank_latch #(
  parameter int NUM_RAS  = 2,
  parameter int IDX_W    = 2,
  parameter int DMA_BANK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_RAS-1:0] ras_in_n,
  input  logic             dma_n,
  input  logic [IDX_W-1:0] addr_idx,
  output logic [IDX_W-1:0] idx_q
);

  localparam logic [IDX_W-1:0] DMA_IDX = IDX_W'(DMA_BANK);

  logic             held_q;
  logic             held_d;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;
  logic             row_active;

  always_comb begin
    row_active = !(&ras_in_n);
    idx_en     = row_active && !held_q;
    held_d     = row_active;
    idx_d      = dma_n ? addr_idx : DMA_IDX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      held_q <= held_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  // Index must not move while the same row cycle is still open.
  p_idx_stable_in_cycle_r4: assert property (
    @(posedge clk) disable iff (!rst_n)
      (held_q && row_active) |=> $stable(idx_q));

  // A capture during DMA lands on the second chip bank.
  p_dma_forces_bank_r8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (!held_q && row_active && !dma_n) |=> (idx_q == DMA_IDX));

endmodule

// File: rtl/steer_cas_demux.sv
module steer_cas_demux #(
  parameter int NUM_BANKS = 4,
  parameter int LANES     = 2,
  parameter int IDX_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             idx,
  input  logic [LANES-1:0]             cas_in_n,
  output logic [NUM_BANKS*LANES-1:0]   cas_out_n
);

  logic [LANES-1:0][NUM_BANKS-1:0] lane_view_n;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
        if (idx == IDX_W'(b)) cas_out_n[b*LANES+l] = cas_in_n[l];
        else                  cas_out_n[b*LANES+l] = 1'b1;
      end
      assign lane_view_n[l][b] = cas_out_n[b*LANES+l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // A byte lane strobe reaches at most one bank.
    p_one_bank_per_lane_r5: assert property (
      @(posedge clk) disable iff (!rst_n)
        $onehot0(~lane_view_n[l]));
  end

  // No column strobe in means none out.
  p_idle_cas_high_r6: assert property (
    @(posedge clk) disable iff (!rst_n)
      (&cas_in_n) |-> (&cas_out_n));

endmodule

// File: rtl/dram_bank_steer.sv
module dram_bank_steer
  import dram_steer_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          BANK_BIT  = 19,
  parameter int          HIGH_BIT  = 23,
  parameter int          NUM_BANKS = 4,
  parameter int          LANES     = 2,
  parameter int          NUM_RAS   = 2,
  parameter int          DMA_BANK  = 1,
  parameter logic [23:0] SLOW_BASE = 24'hC00000,
  parameter logic [23:0] SLOW_END  = 24'hD7FFFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic                       cpu_as_n,
  input  logic                       cfg_contig,
  input  logic                       dma_n,
  input  logic [NUM_RAS-1:0]         ras_in_n,
  input  logic [LANES-1:0]           cas_in_n,
  output logic                       ram_en_n,
  output logic                       reg_en_n,
  output logic                       bank_sel,
  output logic [NUM_RAS-1:0]         ras_out_n,
  output logic [NUM_BANKS*LANES-1:0] cas_out_n
);

  localparam int IDX_W = $clog2(NUM_BANKS);

  logic             rst_sync_n;
  decode_t          dec;
  logic [IDX_W-1:0] idx_q;

  steer_reset_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  steer_addr_decode #(
    .ADDR_W    (ADDR_W),
    .BANK_BIT  (BANK_BIT),
    .HIGH_BIT  (HIGH_BIT),
    .SLOW_BASE (SLOW_BASE),
    .SLOW_END  (SLOW_END)
  ) i_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cpu_addr   (cpu_addr),
    .cpu_as_n   (cpu_as_n),
    .cfg_contig (cfg_contig),
    .dec        (dec)
  );

  steer_bank_latch #(
    .NUM_RAS  (NUM_RAS),
    .IDX_W    (IDX_W),
    .DMA_BANK (DMA_BANK)
  ) i_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ras_in_n (ras_in_n),
    .dma_n    (dma_n),
    .addr_idx (cpu_addr[BANK_BIT +: IDX_W]),
    .idx_q    (idx_q)
  );

  steer_cas_demux #(
    .NUM_BANKS (NUM_BANKS),
    .LANES     (LANES),
    .IDX_W     (IDX_W)
  ) i_cas (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .idx       (idx_q),
    .cas_in_n  (cas_in_n),
    .cas_out_n (cas_out_n)
  );

  // Row strobes go to the banks untouched so refresh reaches all of them.
  assign ras_out_n = ras_in_n;
  assign ram_en_n  = !dec.ram_hit;
  assign reg_en_n  = !dec.ext_hit;
  assign bank_sel  = dec.sel_bit;

endmodule

// File: tb/test_dram_bank_steer.sv
module test_dram_bank_steer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] cpu_addr;
  logic        cpu_as_n;
  logic        cfg_contig;
  logic        dma_n;
  logic [1:0]  ras_in_n;
  logic [1:0]  cas_in_n;
  logic        ram_en_n;
  logic        reg_en_n;
  logic        bank_sel;
  logic [1:0]  ras_out_n;
  logic [7:0]  cas_out_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state
  int m_idx  = 0;
  bit m_held = 1'b0;

  always #10 clk = ~clk;

  dram_bank_steer i_dram_bank_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_as_n   (cpu_as_n),
    .cfg_contig (cfg_contig),
    .dma_n      (dma_n),
    .ras_in_n   (ras_in_n),
    .cas_in_n   (cas_in_n),
    .ram_en_n   (ram_en_n),
    .reg_en_n   (reg_en_n),
    .bank_sel   (bank_sel),
    .ras_out_n  (ras_out_n),
    .cas_out_n  (cas_out_n)
  );

  // Behavioural model of the index register
  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx  <= 0;
      m_held <= 1'b0;
    end else if (ras_in_n != 2'b11) begin
      if (!m_held) m_idx <= (!dma_n) ? 1 : int'(cpu_addr[20:19]);
      m_held <= 1'b1;
    end else begin
      m_held <= 1'b0;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic compare(input string lbl);
    int a;
    bit hit;
    bit ext;
    bit sel;
    logic [7:0] c;
    a   = int'(cpu_addr);
    hit = 1'b0;
    if (!cpu_as_n) begin
      if (a < 'h080000) hit = 1'b1;
      if (cfg_contig && a < 'h100000) hit = 1'b1;
      if (a >= 'hC00000 && a <= 'hD7FFFF) hit = 1'b1;
    end
    ext = !cpu_as_n && a >= 'hC80000 && a <= 'hD7FFFF;
    sel = cfg_contig ? cpu_addr[19] : cpu_addr[23];
    c   = 8'hFF;
    for (int l = 0; l < 2; l++) c[m_idx*2+l] = cas_in_n[l];
    chk({lbl, " R1/R3 ram_en_n"}, int'(ram_en_n), int'(!hit));
    chk({lbl, " R3 reg_en_n"}, int'(reg_en_n), int'(!ext));
    chk({lbl, " R2 bank_sel"}, int'(bank_sel), int'(sel));
    chk({lbl, " R7 ras_out_n"}, int'(ras_out_n), int'(ras_in_n));
    chk({lbl, " R5 cas_out_n"}, int'(cas_out_n), int'(c));
  endtask

  task automatic step(input logic [23:0] ad, input logic as_n, input logic ctg,
                      input logic dn, input logic [1:0] ras, input logic [1:0] cas,
                      input string lbl);
    @(negedge clk);
    cpu_addr   = ad;
    cpu_as_n   = as_n;
    cfg_contig = ctg;
    dma_n      = dn;
    ras_in_n   = ras;
    cas_in_n   = cas;
    #2;
    compare(lbl);
  endtask

  initial begin
    rst_n      = 1'b0;
    cpu_addr   = '0;
    cpu_as_n   = 1'b1;
    cfg_contig = 1'b0;
    dma_n      = 1'b1;
    ras_in_n   = 2'b11;
    cas_in_n   = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9: reset state, bank 0 steering
    step(24'h000000, 1'b1, 1'b0, 1'b1, 2'b11, 2'b11, "R9 idle");
    step(24'h000000, 1'b1, 1'b0, 1'b1, 2'b11, 2'b10, "R9 cas to bank0");
    chk("R9 bank0 lower", int'(cas_out_n), 'hFE);

    // R1 / R2 decode, split and contiguous
    step(24'h000000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R1 base");
    step(24'h07FFFF, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R1 top");
    step(24'h080000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R2 split above");
    chk("R2 split not ram", int'(ram_en_n), 1);
    step(24'h080000, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, "R2 contig");
    chk("R2 contig ram", int'(ram_en_n), 0);
    step(24'h0FFFFF, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, "R2 contig top");
    step(24'h100000, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, "R2 contig end");
    step(24'hC00000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R2 A23 select");
    chk("R2 bank_sel A23", int'(bank_sel), 1);
    step(24'h000000, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11, "R1 bus idle");

    // R3 slow window edges
    step(24'hBFFFFF, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R3 below");
    step(24'hC7FFFF, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R3 first slow");
    step(24'hC80000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R3 ext start");
    chk("R3 reg_en at C80000", int'(reg_en_n), 0);
    step(24'hD7FFFF, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11, "R3 window end");
    step(24'hD80000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R3 past end");
    chk("R3 D80000 not ram", int'(ram_en_n), 1);
    step(24'hFFFFFF, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R3 top of map");

    // R4 capture and hold, bank 2 via 0xD00000
    step(24'hD00000, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11, "R4 ras fall");
    step(24'h000000, 1'b0, 1'b0, 1'b1, 2'b10, 2'b01, "R4 hold upper");
    chk("R4 upper on bank2", int'(cas_out_n), 'hDF);
    step(24'hC80000, 1'b0, 1'b0, 1'b0, 2'b10, 2'b00, "R4 hold both");
    step(24'hC80000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R6 release");
    step(24'hC80000, 1'b0, 1'b0, 1'b1, 2'b01, 2'b11, "R4 ras1 fall");
    step(24'hC80000, 1'b0, 1'b0, 1'b1, 2'b01, 2'b10, "R5 lower bank1");
    step(24'hD80000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R6 idle");

    // R8 DMA forces bank 1 despite a bank-3 address
    step(24'hD80000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, "R8 prep");
    step(24'h180000, 1'b1, 1'b0, 1'b0, 2'b10, 2'b11, "R8 dma ras");
    step(24'h180000, 1'b1, 1'b0, 1'b0, 2'b10, 2'b00, "R8 dma cas");
    chk("R8 bank1 both lanes", int'(cas_out_n), 'hF3);
    step(24'h180000, 1'b1, 1'b0, 1'b1, 2'b11, 2'b11, "R8 end");
    // Bank 3 capture for comparison
    step(24'h180000, 1'b0, 1'b1, 1'b1, 2'b00, 2'b11, "R4 bank3 ras");
    step(24'h180000, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, "R5 bank3 cas");
    chk("R5 bank3 both lanes", int'(cas_out_n), 'h3F);
    // R6: CAS idle with RAS low still gives all high; R7 during refresh
    step(24'h180000, 1'b0, 1'b1, 1'b1, 2'b00, 2'b11, "R6 cas idle");
    step(24'h000000, 1'b1, 1'b0, 1'b1, 2'b11, 2'b11, "R7 refresh gap");

    // Row strobes walked through all codes
    for (int k = 0; k < 4; k++)
      step(24'h040000, 1'b1, 1'b0, 1'b1, 2'(k), 2'b11, "R7 ras walk");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule